// File: doc/BRIEF.md
# Grouped Pin-Toggle Interrupt Aggregator

This block watches thirty-two general-purpose pins and folds their activity into four interrupt flags. The pins form four groups of eight: group 0 holds pins 7:0, group 1 holds pins 15:8, group 2 holds pins 23:16 and group 3 holds pins 31:24. Each group has its own eight-bit enable mask. A group flag goes up when any enabled pin in that group changes level, in either direction. The pins are sampled the same way whatever drives them, so a pin the system itself drives as an output raises its group in the same way and can be used as a software-triggered interrupt. A four-bit gate register decides which flags reach the request outputs. Software clears flags by writing ones.

A low-power path handles deep sleep. While the sleep input is high, the first enabled toggle does not set a flag. Instead it records the pin levels from just before the toggle and raises a wake request. When the wake-done pulse arrives, each group's enabled pins are compared with that record. A group is flagged only if its pins still differ from the record. A pin that has already gone back to its old level lets the wake finish but leaves no flag.

Software reaches the masks, flags and gate through a small register port with a combinational read.

Top module: `pin_toggle_irq`

## Requirements
- R1: Pin i belongs to group i/8, and a toggle on an enabled pin sets only that group's flag (flag bit g = group g).
- R2: After reset all masks are zero, and a toggle on a pin whose mask bit is zero sets no flag.
- R3: Outside sleep, a rising or falling change on an enabled pin shows in the flag register on the third rising clock edge after the change reaches the pin inputs.
- R4: Writing the flag register (address 4) clears each flag bit written as 1 and leaves the bits written as 0 unchanged.
- R5: If a flag is set by a toggle and cleared by a write on the same edge, the flag ends up set.
- R6: irq_o bit g is high exactly when flag g is set and gate bit g (address 5, bits 3:0) is set.
- R7: While sleep_i is high, an enabled toggle raises wake_req_o on the same edge a flag would have been set, and no flag is set before the wake-done pulse.
- R8: On a wake_done_i pulse while wake_req_o is high, wake_req_o drops and a group flag is set only if that group's enabled pins differ from their levels just before the first toggle. A pin that has returned to its old level sets no flag.
- R9: Addresses 0 to 3 read and write the masks of groups 0 to 3. Address 4 reads the flags and address 5 reads the gate, each in bits 3:0 with the upper bits zero. Addresses 6 and 7 read zero, and writes to them change nothing.
- R10: After reset the flags, the gate, irq_o and wake_req_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Monitored pin levels |
| sleep_i | input | 1 | High while the system is in deep sleep |
| wake_done_i | input | 1 | One-cycle pulse when the wake sequence completes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| irq_o | output | 4 | Gated group interrupt requests |
| wake_req_o | output | 1 | Wake request raised during sleep |

## Verification
A pin change takes three rising edges to reach the flags: two synchronizer stages and then the flag register. The bench changes pins just after a falling edge and waits three falling edges before it reads, so every result is settled when it is sampled. Register writes take effect on the following edge, and reads are combinational, so each read takes place half a cycle after the address is set. For the set-versus-clear race, the write strobe is placed on exactly the third edge after the pin change. The wake-done pulse is resolved on the edge where it is sampled, and the results are checked one falling edge later.

// File: rtl/pti_pkg.sv
package pti_pkg;
  localparam int unsigned PTI_GROUPS  = 4;
  localparam int unsigned PTI_GROUP_W = 8;
  localparam int unsigned PTI_ADDR_W  = 3;

  // Pins of one group that moved between two samples and are enabled.
  function automatic logic [PTI_GROUP_W-1:0] pti_edges(
      input logic [PTI_GROUP_W-1:0] now_v,
      input logic [PTI_GROUP_W-1:0] ref_v,
      input logic [PTI_GROUP_W-1:0] mask_v);
    return (now_v ^ ref_v) & mask_v;
  endfunction
endpackage

// File: rtl/pti_sync.sv
module pti_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pins_i;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign cur_o  = stage2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pti_group_det.sv
module pti_group_det
  import pti_pkg::*;
(
  input  logic [PTI_GROUP_W-1:0] cur_i,
  input  logic [PTI_GROUP_W-1:0] prev_i,
  input  logic [PTI_GROUP_W-1:0] snap_i,
  input  logic [PTI_GROUP_W-1:0] mask_i,
  output logic                   hit_o,
  output logic                   drift_o
);
  logic [PTI_GROUP_W-1:0] edges_w, moved_w;

  assign edges_w = pti_edges(cur_i, prev_i, mask_i);
  assign moved_w = pti_edges(cur_i, snap_i, mask_i);
  assign hit_o   = |edges_w;
  assign drift_o = |moved_w;
endmodule

// File: rtl/pti_wake_ctl.sv
module pti_wake_ctl #(
  parameter int unsigned W    = 32,
  parameter int unsigned NGRP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_i,
  input  logic            wake_done_i,
  input  logic [NGRP-1:0] hit_i,
  input  logic [NGRP-1:0] drift_i,
  input  logic [W-1:0]    prev_i,
  output logic [W-1:0]    snap_o,
  output logic            armed_o,
  output logic [NGRP-1:0] set_o
);
  logic         armed_q;
  logic [W-1:0] snap_q;
  logic         capture_w, resolve_w;

  assign capture_w = sleep_i && !armed_q && (|hit_i);
  assign resolve_w = armed_q && wake_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      if (resolve_w)      armed_q <= 1'b0;
      else if (capture_w) armed_q <= 1'b1;
      if (capture_w)      snap_q  <= prev_i;
    end
  end

  always_comb begin
    if (resolve_w)                 set_o = drift_i;
    else if (sleep_i || armed_q)   set_o = '0;
    else                           set_o = hit_i;
  end

  assign snap_o  = snap_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/pti_regs.sv
module pti_regs
  import pti_pkg::*;
#(
  parameter int unsigned NGRP   = PTI_GROUPS,
  parameter int unsigned ADDR_W = PTI_ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [PTI_GROUP_W-1:0]      wdata_i,
  input  logic [NGRP-1:0]             set_i,
  output logic [NGRP*PTI_GROUP_W-1:0] mask_o,
  output logic [NGRP-1:0]             flag_o,
  output logic [NGRP-1:0]             gate_o,
  output logic [PTI_GROUP_W-1:0]      rdata_o
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NGRP);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(NGRP + 1);

  logic [NGRP-1:0] flag_q, gate_q, clr_w;
  logic            unused_hi;

  assign unused_hi = ^wdata_i[PTI_GROUP_W-1:NGRP];
  assign clr_w     = (we_i && addr_i == A_FLAG) ? wdata_i[NGRP-1:0] : '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_mask
    logic [PTI_GROUP_W-1:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mask_q <= '0;
      else if (we_i && addr_i == ADDR_W'(g))      mask_q <= wdata_i;
    end
    assign mask_o[g*PTI_GROUP_W +: PTI_GROUP_W] = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      gate_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_w) | set_i;
      if (we_i && addr_i == A_GATE) gate_q <= wdata_i[NGRP-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NGRP; g++)
      if (addr_i == ADDR_W'(g)) rdata_o = mask_o[g*PTI_GROUP_W +: PTI_GROUP_W];
    if (addr_i == A_FLAG) rdata_o = PTI_GROUP_W'(flag_q);
    if (addr_i == A_GATE) rdata_o = PTI_GROUP_W'(gate_q);
  end

  assign flag_o = flag_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq
  import pti_pkg::*;
#(
  parameter int unsigned NGRP   = PTI_GROUPS,
  parameter int unsigned ADDR_W = PTI_ADDR_W,
  localparam int unsigned NPINS = NGRP * PTI_GROUP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pins_i,
  input  logic                   sleep_i,
  input  logic                   wake_done_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [PTI_GROUP_W-1:0] reg_wdata_i,
  output logic [PTI_GROUP_W-1:0] reg_rdata_o,
  output logic [NGRP-1:0]        irq_o,
  output logic                   wake_req_o
);
  logic [NPINS-1:0] cur_w, prev_w, snap_w, mask_w;
  logic [NGRP-1:0]  hit_w, drift_w, set_vec, flag_q, gate_q;
  logic             armed;

  pti_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cur_o(cur_w), .prev_o(prev_w)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_det
    pti_group_det u_det (
      .cur_i  (cur_w [g*PTI_GROUP_W +: PTI_GROUP_W]),
      .prev_i (prev_w[g*PTI_GROUP_W +: PTI_GROUP_W]),
      .snap_i (snap_w[g*PTI_GROUP_W +: PTI_GROUP_W]),
      .mask_i (mask_w[g*PTI_GROUP_W +: PTI_GROUP_W]),
      .hit_o  (hit_w[g]),
      .drift_o(drift_w[g])
    );
  end

  pti_wake_ctl #(.W(NPINS), .NGRP(NGRP)) u_wake (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .wake_done_i(wake_done_i),
    .hit_i(hit_w), .drift_i(drift_w), .prev_i(prev_w),
    .snap_o(snap_w), .armed_o(armed), .set_o(set_vec)
  );

  pti_regs #(.NGRP(NGRP), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .set_i(set_vec), .mask_o(mask_w),
    .flag_o(flag_q), .gate_o(gate_q), .rdata_o(reg_rdata_o)
  );

  assign irq_o      = flag_q & gate_q;
  assign wake_req_o = armed;
endmodule

// File: rtl/pin_toggle_irq_chk.sv
module pin_toggle_irq_chk #(
  parameter int unsigned NGRP   = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_i,
  input logic              wake_done_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic              wake_req_o,
  input logic              armed,
  input logic [NGRP-1:0]   set_vec,
  input logic [NGRP-1:0]   flag_q
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NGRP);

  // R5: a set request always lands, even against a clear.
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R4: written ones clear flags that are not being set.
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == A_FLAG)
      |=> ((flag_q & $past(reg_wdata_i[NGRP-1:0] & ~set_vec)) == '0));

  // R7: no flag rises while asleep without a wake-done pulse.
  p_quiet_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !wake_done_i) |=> ((flag_q & ~$past(flag_q)) == '0));

  // R7: a wake request only starts during sleep.
  p_wake_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> $past(sleep_i));

  // R8: wake-done ends a pending wake.
  p_wake_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wake_done_i) |=> !wake_req_o);
endmodule

bind pin_toggle_irq pin_toggle_irq_chk #(
  .NGRP(NGRP), .ADDR_W(ADDR_W), .DW(pti_pkg::PTI_GROUP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .wake_done_i(wake_done_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .wake_req_o(wake_req_o), .armed(armed), .set_vec(set_vec), .flag_q(flag_q)
);

// File: tb/tb_pin_toggle_irq.sv
module tb_pin_toggle_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins_i = '0;
  logic        sleep_i = 1'b0, wake_done_i = 1'b0, reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [3:0]  irq_o;
  logic        wake_req_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] m [4];
  logic [3:0] exp_flags = '0, gate = '0;

  pin_toggle_irq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] hits(input logic [31:0] diff);
    logic [3:0] h;
    for (int g = 0; g < 4; g++) h[g] = |(diff[g*8 +: 8] & m[g]);
    return h;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr_i = a; #1; v = reg_rdata_o;
  endtask

  task automatic move_pins(input logic [31:0] nv);
    @(negedge clk); pins_i = nv;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mask(input int g, input logic [7:0] v);
    wr(3'(g), v); m[g] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [31:0] np;
    void'($urandom(32'd4711));
    for (int g = 0; g < 4; g++) m[g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 / R2 reset state
    rd(3'd4, v); check("R10 flags", v, 0);
    rd(3'd5, v); check("R10 gate", v, 0);
    check("R10 irq", irq_o, 0);
    check("R10 wake", wake_req_o, 0);
    for (int g = 0; g < 4; g++) begin rd(3'(g), v); check("R2 mask reset", v, 0); end

    // R2 masked toggles do nothing
    move_pins(32'hFFFF_FFFF); rd(3'd4, v); check("R2 masked", v, 0);
    move_pins(32'h0);

    // R9 register map
    set_mask(2, 8'hA5); rd(3'd2, v); check("R9 mask2", v, 8'hA5);
    wr(3'd7, 8'hFF); wr(3'd6, 8'hFF);
    rd(3'd7, v); check("R9 addr7", v, 0);
    rd(3'd6, v); check("R9 addr6", v, 0);
    rd(3'd2, v); check("R9 mask2 kept", v, 8'hA5);
    rd(3'd4, v); check("R9 flags kept", v, 0);

    // R1 / R3 grouping, both directions
    for (int g = 0; g < 4; g++) set_mask(g, 8'hFF);
    move_pins(32'h0000_0200); rd(3'd4, v); check("R1 pin9 group1", v, 8'h02);
    wr(3'd4, 8'h0F);
    move_pins(32'h0);          rd(3'd4, v); check("R3 falling", v, 8'h02);
    wr(3'd4, 8'h0F);

    // R3 exact timing: not yet after two edges, set after three
    @(negedge clk); pins_i = 32'h0100_0000;
    @(negedge clk); @(negedge clk); reg_addr_i = 3'd4; #1;
    check("R3 not early", reg_rdata_o, 0);
    @(negedge clk); #1; check("R3 third edge", reg_rdata_o, 8'h08);

    // R4 writing zeros keeps, ones clear
    wr(3'd4, 8'h00); rd(3'd4, v); check("R4 zero write", v, 8'h08);
    wr(3'd4, 8'h08); rd(3'd4, v); check("R4 clear", v, 8'h00);

    // R5 set wins over clear on the same edge
    move_pins(32'h0100_0001); rd(3'd4, v); check("R5 pre", v, 8'h01);
    @(negedge clk); pins_i = 32'h0100_0000;
    @(negedge clk); @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 8'h01;
    @(negedge clk); reg_we_i = 1'b0;
    rd(3'd4, v); check("R5 set wins", v, 8'h01);
    wr(3'd4, 8'h0F);
    pins_i = 32'h0; repeat (4) @(negedge clk); wr(3'd4, 8'h0F);

    // random normal-mode traffic: R1 R3 R4 R6
    exp_flags = '0;
    for (int it = 0; it < 60; it++) begin
      if ($urandom % 4 == 0)
        for (int g = 0; g < 4; g++) set_mask(g, 8'($urandom));
      if ($urandom % 3 == 0) begin gate = 4'($urandom); wr(3'd5, {4'h0, gate}); end
      np = pins_i ^ ($urandom & $urandom & $urandom);
      exp_flags |= hits(pins_i ^ np);
      move_pins(np);
      rd(3'd4, v); check("R3 random flags", v, {4'h0, exp_flags});
      check("R6 irq gating", irq_o, exp_flags & gate);
      if ($urandom % 3 == 0) begin
        logic [3:0] c;
        c = 4'($urandom);
        wr(3'd4, {4'h0, c}); exp_flags &= ~c;
        rd(3'd4, v); check("R4 random clear", v, {4'h0, exp_flags});
      end
    end

    // R7 / R8 sleep: pin 2 reverts, pin 17 stays
    wr(3'd4, 8'h0F); wr(3'd5, 8'h0F);
    set_mask(0, 8'hFF); set_mask(1, 8'h00); set_mask(2, 8'h0F); set_mask(3, 8'h00);
    pins_i = 32'h0; repeat (4) @(negedge clk); wr(3'd4, 8'h0F);
    sleep_i = 1'b1;
    move_pins(32'h0000_0004);
    check("R7 wake raised", wake_req_o, 1);
    rd(3'd4, v); check("R7 no flag asleep", v, 0);
    move_pins(32'h0002_0004);
    move_pins(32'h0002_0000);
    rd(3'd4, v); check("R7 still no flag", v, 0);
    @(negedge clk); wake_done_i = 1'b1;
    @(negedge clk); wake_done_i = 1'b0;
    check("R8 wake dropped", wake_req_o, 0);
    rd(3'd4, v); check("R8 only lasting group", v, 8'h04);
    check("R6 irq after wake", irq_o, 4'h4);

    // R8 single reverted pin: no flag at all
    wr(3'd4, 8'h0F);
    move_pins(32'h0002_0008);
    check("R7 wake again", wake_req_o, 1);
    move_pins(32'h0002_0000);
    @(negedge clk); wake_done_i = 1'b1;
    @(negedge clk); wake_done_i = 1'b0;
    rd(3'd4, v); check("R8 reverted no flag", v, 0);
    check("R8 wake dropped 2", wake_req_o, 0);
    sleep_i = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule